// File: doc/BRIEF.md
# Two-Tier Line Silence Alarm

This block watches the recovered receive data of one E1 channel and reports when the line has gone quiet. At each rising edge of the recovered bit clock it looks at the positive-rail and negative-rail mark indications for that bit. A bit with no mark on either rail is a zero. One counter holds the length of the current run of consecutive zeros. Two alarms are taken from that counter.

The short alarm (`los_flag`) compares the run against a threshold that software or straps supply. The block clamps that threshold to the range 10 to 255 bits, so the alarm is always declared within 255 bit periods of the line going quiet. The long alarm (`exlos_flag`) uses a fixed run of 4096 zeros. The counter keeps running past the short threshold and stops at 4096, so the long alarm stays high for as long as the outage lasts.

Any mark clears the run and both alarms. A multi-channel wrapper uses one instance per channel.

Top module: `line_silence_monitor`

## Requirements
- R1: Each rising clock edge that samples `rx_pos`=0 and `rx_neg`=0 raises `run_len` by exactly 1, visible after that edge.
- R2: An edge that samples `rx_pos`=1 or `rx_neg`=1, or both, sets `run_len` to 0. Both `los_flag` and `exlos_flag` are low after that same edge.
- R3: `los_flag` is 1 exactly when `run_len` is greater than or equal to the effective threshold. With an in-range `los_limit` of 20, it rises after the 20th consecutive zero and not after the 19th.
- R4: A `los_limit` below 10 (including 0) gives an effective threshold of 10.
- R5: A `los_limit` above 255 gives an effective threshold of 255, so `los_flag` rises after the 255th zero.
- R6: `exlos_flag` is 1 exactly when `run_len` has reached 4096. It is still 0 after the 4095th zero.
- R7: `run_len` saturates at 4096. Further zeros leave it at 4096 and it does not wrap.
- R8: `exlos_flag` is never 1 while `los_flag` is 0.
- R9: With `rst`=1 at a rising edge, `run_len` becomes 0 and both alarms go low after that edge. Zero bits that arrive during reset are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_pos | input | 1 | Positive-rail mark seen in this bit interval |
| rx_neg | input | 1 | Negative-rail mark seen in this bit interval |
| los_limit | input | 9 | Requested short-alarm threshold in bits (clamped to 10..255) |
| los_flag | output | 1 | Short loss-of-signal alarm |
| exlos_flag | output | 1 | Extended loss-of-signal alarm (4096 zeros) |
| run_len | output | 13 | Current consecutive-zero run length, saturating at 4096 |

## Verification
On every cycle, the embedded assertions check the following:
- the clamped threshold stays inside 10..255;
- the run either grows by one, holds at its ceiling, or returns to zero after a mark;
- the long alarm never appears without the short one;
- a mark always leaves both alarms low.

Only the directed scenarios can show the exact bit at which each alarm rises. This covers clamping at both ends, the 4095/4096 boundary, reset arriving partway through a run, and marks on each rail taken separately.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int unsigned THR_MIN  = 10;
  localparam int unsigned THR_MAX  = 255;
  localparam int unsigned THR_W    = 9;
  localparam int unsigned THR_OUTW = 8;
  localparam int unsigned EXT_RUN  = 4096;
  localparam int unsigned RUN_W    = $clog2(EXT_RUN + 1);

  typedef logic [RUN_W-1:0]    run_t;
  typedef logic [THR_OUTW-1:0] thr_t;

  // Force a requested threshold into the legal window.
  function automatic thr_t clamp_threshold(input logic [THR_W-1:0] req);
    if (req < THR_W'(THR_MIN))      return thr_t'(THR_MIN);
    else if (req > THR_W'(THR_MAX)) return thr_t'(THR_MAX);
    else                            return thr_t'(req);
  endfunction

  // Next run length: clear on mark, else step up to the ceiling.
  function automatic run_t next_run(input run_t cur, input logic mark);
    if (mark)                         return '0;
    else if (cur >= run_t'(EXT_RUN))  return run_t'(EXT_RUN);
    else                              return cur + run_t'(1);
  endfunction
endpackage

// File: rtl/lsm_thresh_clamp.sv
module lsm_thresh_clamp
  import lsm_pkg::*;
(
  input  logic [THR_W-1:0] req_thr,
  output thr_t             eff_thr
);
  assign eff_thr = clamp_threshold(req_thr);

  // R4 R5
  always_comb begin
    eff_thr_window_chk: assert (eff_thr >= thr_t'(THR_MIN) && eff_thr <= thr_t'(THR_MAX));
  end
endmodule

// File: rtl/lsm_run_counter.sv
module lsm_run_counter
  import lsm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_has_mark,
  output run_t run_q,
  output logic at_ceiling
);
  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= next_run(run_q, bit_has_mark);
  end

  assign at_ceiling = (run_q == run_t'(EXT_RUN));

  // R1
  // step_by_one_chk
  step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_has_mark && !at_ceiling) |=> (run_q == $past(run_q) + run_t'(1)));

  // R7
  // no_wrap_chk
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_has_mark && at_ceiling) |=> at_ceiling);

  // R2
  // mark_clears_run_chk
  mark_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
    bit_has_mark |=> (run_q == '0));
endmodule

// File: rtl/lsm_alarm_gen.sv
module lsm_alarm_gen
  import lsm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  run_t run_q,
  input  thr_t eff_thr,
  input  logic at_ceiling,
  output logic los_hit,
  output logic exlos_hit
);
  assign los_hit   = (run_q >= run_t'(eff_thr));
  assign exlos_hit = at_ceiling;

  // R8
  // nested_alarm_chk
  nested_alarm_chk: assert property (@(posedge clk) disable iff (rst)
    exlos_hit |-> los_hit);
endmodule

// File: rtl/line_silence_monitor.sv
module line_silence_monitor
  import lsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_pos,
  input  logic             rx_neg,
  input  logic [THR_W-1:0] los_limit,
  output logic             los_flag,
  output logic             exlos_flag,
  output logic [RUN_W-1:0] run_len
);
  logic bit_has_mark;
  thr_t eff_thr;
  run_t run_q;
  logic at_ceiling;
  logic los_hit;
  logic exlos_hit;

  assign bit_has_mark = rx_pos | rx_neg;

  lsm_thresh_clamp u_clamp (
    .req_thr (los_limit),
    .eff_thr (eff_thr)
  );

  lsm_run_counter u_count (
    .clk          (clk),
    .rst          (rst),
    .bit_has_mark (bit_has_mark),
    .run_q        (run_q),
    .at_ceiling   (at_ceiling)
  );

  lsm_alarm_gen u_alarm (
    .clk        (clk),
    .rst        (rst),
    .run_q      (run_q),
    .eff_thr    (eff_thr),
    .at_ceiling (at_ceiling),
    .los_hit    (los_hit),
    .exlos_hit  (exlos_hit)
  );

  assign los_flag   = los_hit;
  assign exlos_flag = exlos_hit;
  assign run_len    = run_q;

  // R2
  // mark_quiets_alarms_chk
  mark_quiets_alarms_chk: assert property (@(posedge clk) disable iff (rst)
    bit_has_mark |=> (!los_flag && !exlos_flag));
endmodule

// File: tb/line_silence_monitor_test.sv
module line_silence_monitor_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_pos = 1'b0;
  logic       rx_neg = 1'b0;
  logic [8:0] los_limit = 9'd20;
  logic       los_flag;
  logic       exlos_flag;
  logic [12:0] run_len;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  line_silence_monitor uut (
    .clk(clk), .rst(rst), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .los_limit(los_limit), .los_flag(los_flag),
    .exlos_flag(exlos_flag), .run_len(run_len)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one bit at the falling edge, let the rising edge take it, sample just after.
  task automatic bit_in(input logic p, input logic n);
    @(negedge clk);
    rx_pos = p; rx_neg = n;
    @(posedge clk);
    #1;
  endtask

  task automatic zeros(input int k);
    for (int i = 0; i < k; i++) bit_in(1'b0, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1; rx_pos = 1'b0; rx_neg = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R9", "run_len in reset", int'(run_len), 0);
    chk("R9", "los in reset", int'(los_flag), 0);
    chk("R9", "exlos in reset", int'(exlos_flag), 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_basic_threshold;
    los_limit = 9'd20;
    bit_in(1'b1, 1'b0);
    zeros(19);
    chk("R1", "run after 19 zeros", int'(run_len), 19);
    chk("R3", "los after 19 of 20", int'(los_flag), 0);
    zeros(1);
    chk("R3", "los after 20 of 20", int'(los_flag), 1);
    chk("R1", "run after 20 zeros", int'(run_len), 20);
  endtask

  task automatic t_rail_marks;
    los_limit = 9'd20;
    bit_in(1'b1, 1'b0); zeros(25);
    bit_in(1'b1, 1'b0);
    chk("R2", "run after pos mark", int'(run_len), 0);
    chk("R2", "los after pos mark", int'(los_flag), 0);
    zeros(25);
    bit_in(1'b0, 1'b1);
    chk("R2", "run after neg mark", int'(run_len), 0);
    chk("R2", "los after neg mark", int'(los_flag), 0);
    zeros(3);
    bit_in(1'b1, 1'b1);
    chk("R2", "run after both marks", int'(run_len), 0);
  endtask

  task automatic t_clamp_low;
    los_limit = 9'd3;
    bit_in(1'b1, 1'b0); zeros(9);
    chk("R4", "los after 9 with limit 3", int'(los_flag), 0);
    zeros(1);
    chk("R4", "los after 10 with limit 3", int'(los_flag), 1);
    los_limit = 9'd0;
    bit_in(0, 1); zeros(9);
    chk("R4", "los after 9 with limit 0", int'(los_flag), 0);
    zeros(1);
    chk("R4", "los after 10 with limit 0", int'(los_flag), 1);
  endtask

  task automatic t_clamp_high;
    los_limit = 9'd400;
    bit_in(1'b1, 1'b0); zeros(254);
    chk("R5", "los after 254 with limit 400", int'(los_flag), 0);
    zeros(1);
    chk("R5", "los after 255 with limit 400", int'(los_flag), 1);
  endtask

  task automatic t_extended;
    los_limit = 9'd255;
    bit_in(1'b1, 1'b0); zeros(4095);
    chk("R6", "exlos after 4095", int'(exlos_flag), 0);
    chk("R8", "los during long run", int'(los_flag), 1);
    zeros(1);
    chk("R6", "exlos after 4096", int'(exlos_flag), 1);
    chk("R8", "los with exlos", int'(los_flag), 1);
    zeros(10);
    chk("R7", "run saturated", int'(run_len), 4096);
    chk("R7", "exlos held", int'(exlos_flag), 1);
    bit_in(1'b0, 1'b1);
    chk("R2", "exlos after mark", int'(exlos_flag), 0);
    chk("R2", "run after mark at ceiling", int'(run_len), 0);
  endtask

  task automatic t_reset_mid_run;
    los_limit = 9'd20;
    bit_in(1'b1, 1'b0); zeros(30);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R9", "run after mid-run reset", int'(run_len), 0);
    chk("R9", "los after mid-run reset", int'(los_flag), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", "first zero after reset", int'(run_len), 1);
  endtask

  initial begin
    t_reset();
    t_basic_threshold();
    t_rail_marks();
    t_clamp_low();
    t_clamp_high();
    t_extended();
    t_reset_mid_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule